// File: doc/BRIEF.md
# Endpoint Test Function Controller

This block is a register-driven test function of the kind placed behind a PCIe endpoint so that host software can exercise a root complex. Software programs buffer addresses, a byte count and an interrupt choice through a small register bus, then writes a command. The block either raises an interrupt straight away or moves data to or from a modelled host buffer space through a simple byte-wide memory-request port. When it finishes, it reports the outcome in a status register and signals completion on a sideband interrupt-request output.

Data movement has three forms. A write fills the destination buffer with a counting byte pattern. A read checks the source buffer against that same pattern. A copy moves bytes from the source buffer to the destination buffer. Before any access is made, each buffer range is checked against the host window and for alignment. The interrupt type and number pair is checked for legality before any interrupt is sent.

Top module: `ep_test_ctrl`

## Requirements
- R1: The register word index on `reg_addr` selects: 0 magic, 1 command, 2 status, 3 source address, 4 destination address, 5 interrupt type, 6 interrupt number, 7 byte count. The magic register and the other configuration registers (3 to 7) read back the last value written, in full 32 bits.
- R2: Command bits: bit 0 raise legacy, bit 1 raise MSI, bit 2 raise MSI-X, bit 3 read, bit 4 write, bit 5 copy. A raise command sends only an interrupt, of the configured type. If several bits are written at once, only the lowest set bit is acted on.
- R3: Status bits: 0 read ok, 1 read fail, 2 write ok, 3 write fail, 4 copy ok, 5 copy fail, 6 interrupt sent, 7 source invalid, 8 destination invalid.
- R4: A write stores byte value k mod 256 at destination+k for k = 0 to count-1. A read compares source+k against k mod 256 and reports read ok only if every byte matches, and read fail otherwise.
- R5: A copy transfers count bytes from source+k to destination+k, which costs one read access and one write access per byte.
- R6: An address is invalid if it is not a multiple of 4, or if [address, address+count) leaves the window [HOST_BASE, HOST_BASE+HOST_BYTES). An invalid source (read or copy) sets bit 7, and an invalid destination (write or copy) sets bit 8. Either one sets the operation's fail bit, and no memory access is made.
- R7: A byte count of zero completes with the operation's ok bit set, makes no memory access, and skips the address check.
- R8: On completion, `irq_valid` pulses for exactly one cycle carrying the interrupt type register (0 legacy, 1 MSI, 2 MSI-X) and number, and status bit 6 is set.
- R9: The interrupt is legal only for legacy with number 0, MSI with number 1 to 32, or MSI-X with number 1 to 2048. Otherwise no pulse is sent and bit 6 stays clear.
- R10: A command write with any of bits 5:0 set, made while idle, starts an operation and clears status. The command register reads nonzero while the operation is busy and reads zero after it completes. All register writes made while busy are ignored.
- R11: After reset, all registers read zero and neither `irq_valid` nor `mem_req` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mem_req | output | 1 | Host memory access request, one byte |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | 32 | Host byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read request |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_type | output | 2 | Interrupt type for the request |
| irq_num | output | 12 | Interrupt number for the request |

## Verification
The transfer engine is driven with a write followed by a matching read, a read at an offset that misaligns the counting pattern, a copy whose target is then read back, and reads of an untouched region. Together these separate correct data movement from swapped or unused address registers. Unaligned addresses, addresses before the window and addresses past its end, each with zero and nonzero counts, show that a range check is applied to each pointer separately and is bypassed only by a zero count. Raise commands sweep each interrupt type at and beyond its number limits. Multi-bit commands and register writes issued mid-transfer check priority and busy locking. The number of memory accesses is counted for every command.

// File: rtl/ept_pkg.sv
package ept_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_RCHK, ST_WR, ST_FIN} st_e;
    typedef enum logic [1:0] {OP_IRQ, OP_RD, OP_WR, OP_CP} op_e;

    localparam logic [2:0] RA_MAGIC = 3'd0;
    localparam logic [2:0] RA_CMD   = 3'd1;
    localparam logic [2:0] RA_STAT  = 3'd2;
    localparam logic [2:0] RA_SRC   = 3'd3;
    localparam logic [2:0] RA_DST   = 3'd4;
    localparam logic [2:0] RA_ITYPE = 3'd5;
    localparam logic [2:0] RA_INUM  = 3'd6;
    localparam logic [2:0] RA_LEN   = 3'd7;

    localparam int SB_RD_OK  = 0;
    localparam int SB_RD_BAD = 1;
    localparam int SB_WR_OK  = 2;
    localparam int SB_WR_BAD = 3;
    localparam int SB_CP_OK  = 4;
    localparam int SB_CP_BAD = 5;
    localparam int SB_IRQ    = 6;
    localparam int SB_SRC_X  = 7;
    localparam int SB_DST_X  = 8;

    typedef struct packed {
        st_e         st;
        op_e         op;
        logic [5:0]  cmd;
        logic [8:0]  stat;
        logic [31:0] magic;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] len;
        logic [31:0] itype;
        logic [31:0] inum;
        logic [31:0] idx;
        logic        bad;
        logic        irq_v;
    } ctl_t;
endpackage

// File: rtl/ept_cmd_pick.sv
module ept_cmd_pick
    import ept_pkg::*;
(
    input  logic [5:0] cmd_bits,
    output op_e        op,
    output logic       any
);
    always_comb begin
        any = |cmd_bits;
        if (|cmd_bits[2:0])   op = OP_IRQ;
        else if (cmd_bits[3]) op = OP_RD;
        else if (cmd_bits[4]) op = OP_WR;
        else                  op = OP_CP;
    end
endmodule

// File: rtl/ept_addr_win.sv
module ept_addr_win #(
    parameter logic [31:0] HOST_BASE   = 32'h0000_1000,
    parameter int unsigned HOST_BYTES  = 256,
    parameter int unsigned ALIGN_BYTES = 4
) (
    input  logic [31:0] addr,
    input  logic [31:0] len,
    output logic        ok
);
    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

    logic [32:0] off;
    logic [33:0] fin;

    always_comb begin
        off = {1'b0, addr} - {1'b0, HOST_BASE};
        fin = {1'b0, off} + {2'b0, len};
        ok  = (addr[ALIGN_LSB-1:0] == '0) && !off[32] && (fin <= 34'(HOST_BYTES));
    end
endmodule

// File: rtl/ept_irq_legal.sv
module ept_irq_legal #(
    parameter int unsigned MSI_MAX  = 32,
    parameter int unsigned MSIX_MAX = 2048
) (
    input  logic [31:0] itype,
    input  logic [31:0] inum,
    output logic        ok
);
    always_comb begin
        unique case (itype)
            32'd0:   ok = (inum == 32'd0);
            32'd1:   ok = (inum != 32'd0) && (inum <= MSI_MAX);
            32'd2:   ok = (inum != 32'd0) && (inum <= MSIX_MAX);
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ep_test_ctrl.sv
module ep_test_ctrl
    import ept_pkg::*;
#(
    parameter logic [31:0] HOST_BASE  = 32'h0000_1000,
    parameter int unsigned HOST_BYTES = 256,
    parameter int unsigned MSI_MAX    = 32,
    parameter int unsigned MSIX_MAX   = 2048,
    parameter int unsigned IRQ_NUM_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [31:0]          mem_addr,
    output logic [7:0]           mem_wdata,
    input  logic [7:0]           mem_rdata,
    output logic                 irq_valid,
    output logic [1:0]           irq_type,
    output logic [IRQ_NUM_W-1:0] irq_num
);
    ctl_t c_q, c_d;
    op_e  pick_op;
    logic pick_any, src_ok, dst_ok, irq_ok, busy, last_d;

    ept_cmd_pick u_pick (.cmd_bits(reg_wdata[5:0]), .op(pick_op), .any(pick_any));

    ept_addr_win #(.HOST_BASE(HOST_BASE), .HOST_BYTES(HOST_BYTES), .ALIGN_BYTES(4))
        u_src_win (.addr(c_q.src), .len(c_q.len), .ok(src_ok));

    ept_addr_win #(.HOST_BASE(HOST_BASE), .HOST_BYTES(HOST_BYTES), .ALIGN_BYTES(4))
        u_dst_win (.addr(c_q.dst), .len(c_q.len), .ok(dst_ok));

    ept_irq_legal #(.MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX))
        u_irq_ok (.itype(c_q.itype), .inum(c_q.inum), .ok(irq_ok));

    assign busy      = (c_q.st != ST_IDLE);
    assign last_d    = ((c_q.idx + 32'd1) == c_q.len);
    assign irq_valid = c_q.irq_v;
    assign irq_type  = c_q.itype[1:0];
    assign irq_num   = c_q.inum[IRQ_NUM_W-1:0];

    always_comb begin
        unique case (reg_addr)
            RA_MAGIC: reg_rdata = c_q.magic;
            RA_CMD:   reg_rdata = {26'd0, c_q.cmd};
            RA_STAT:  reg_rdata = {23'd0, c_q.stat};
            RA_SRC:   reg_rdata = c_q.src;
            RA_DST:   reg_rdata = c_q.dst;
            RA_ITYPE: reg_rdata = c_q.itype;
            RA_INUM:  reg_rdata = c_q.inum;
            default:  reg_rdata = c_q.len;
        endcase
    end

    always_comb begin
        c_d       = c_q;
        c_d.irq_v = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (reg_we) begin
                    unique case (reg_addr)
                        RA_MAGIC: c_d.magic = reg_wdata;
                        RA_SRC:   c_d.src   = reg_wdata;
                        RA_DST:   c_d.dst   = reg_wdata;
                        RA_ITYPE: c_d.itype = reg_wdata;
                        RA_INUM:  c_d.inum  = reg_wdata;
                        RA_LEN:   c_d.len   = reg_wdata;
                        RA_CMD: if (pick_any) begin
                            c_d.cmd  = reg_wdata[5:0];
                            c_d.stat = '0;
                            c_d.bad  = 1'b0;
                            c_d.idx  = '0;
                            c_d.op   = pick_op;
                            c_d.st   = ST_FIN;
                            if (pick_op != OP_IRQ && c_q.len != 32'd0) begin
                                if (pick_op != OP_WR && !src_ok) begin
                                    c_d.stat[SB_SRC_X] = 1'b1;
                                    c_d.bad            = 1'b1;
                                end
                                if (pick_op != OP_RD && !dst_ok) begin
                                    c_d.stat[SB_DST_X] = 1'b1;
                                    c_d.bad            = 1'b1;
                                end
                                if (!c_d.bad) c_d.st = (pick_op == OP_WR) ? ST_WR : ST_RD;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = c_q.src + c_q.idx;
                c_d.st   = ST_RCHK;
            end
            ST_RCHK: begin
                if (c_q.op == OP_RD) begin
                    if (mem_rdata != c_q.idx[7:0]) c_d.bad = 1'b1;
                end else begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = c_q.dst + c_q.idx;
                    mem_wdata = mem_rdata;
                end
                c_d.idx = c_q.idx + 32'd1;
                c_d.st  = last_d ? ST_FIN : ST_RD;
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = c_q.dst + c_q.idx;
                mem_wdata = c_q.idx[7:0];
                c_d.idx   = c_q.idx + 32'd1;
                c_d.st    = last_d ? ST_FIN : ST_WR;
            end
            default: begin
                unique case (c_q.op)
                    OP_RD: c_d.stat[c_q.bad ? SB_RD_BAD : SB_RD_OK] = 1'b1;
                    OP_WR: c_d.stat[c_q.bad ? SB_WR_BAD : SB_WR_OK] = 1'b1;
                    OP_CP: c_d.stat[c_q.bad ? SB_CP_BAD : SB_CP_OK] = 1'b1;
                    default: ;
                endcase
                if (irq_ok) begin
                    c_d.irq_v        = 1'b1;
                    c_d.stat[SB_IRQ] = 1'b1;
                end
                c_d.cmd = '0;
                c_d.st  = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, op: OP_IRQ, default: '0};
        end else begin
            c_q <= c_d;
        end
    end
endmodule

module ep_test_ctrl_chk #(
    parameter logic [31:0] HOST_BASE  = 32'h0000_1000,
    parameter int unsigned HOST_BYTES = 256,
    parameter int unsigned MSI_MAX    = 32,
    parameter int unsigned MSIX_MAX   = 2048,
    parameter int unsigned IRQ_NUM_W  = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [2:0]           reg_addr,
    input logic [5:0]           cmd_bits,
    input logic                 busy,
    input logic                 mem_req,
    input logic [31:0]          mem_addr,
    input logic                 irq_valid,
    input logic [1:0]           irq_type,
    input logic [IRQ_NUM_W-1:0] irq_num
);
    logic legal;
    always_comb begin
        legal = ((irq_type == 2'd0) && (irq_num == '0)) ||
                ((irq_type == 2'd1) && (irq_num != '0) && (32'(irq_num) <= MSI_MAX)) ||
                ((irq_type == 2'd2) && (irq_num != '0) && (32'(irq_num) <= MSIX_MAX));
    end

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    assert_irq_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !busy);

    assert_irq_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> legal);

    assert_mem_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ({1'b0, mem_addr} >= {1'b0, HOST_BASE}) &&
                    ({1'b0, mem_addr} < ({1'b0, HOST_BASE} + 33'(HOST_BYTES))));

    assert_mem_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd1 && cmd_bits != 6'd0 && !busy) |=> busy);
endmodule

bind ep_test_ctrl ep_test_ctrl_chk #(
    .HOST_BASE(HOST_BASE), .HOST_BYTES(HOST_BYTES), .MSI_MAX(MSI_MAX),
    .MSIX_MAX(MSIX_MAX), .IRQ_NUM_W(IRQ_NUM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .cmd_bits(reg_wdata[5:0]), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .irq_valid(irq_valid), .irq_type(irq_type), .irq_num(irq_num)
);

// File: tb/ep_test_ctrl_tb.sv
module ep_test_ctrl_tb;
    localparam logic [31:0] B = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'd0;
    logic        irq_valid;
    logic [1:0]  irq_type;
    logic [11:0] irq_num;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;
    int acc_cnt = 0;
    logic [1:0]  last_type = '0;
    logic [11:0] last_num = '0;
    logic [7:0]  hmem [256];

    always #4 clk = ~clk;

    ep_test_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq_valid(irq_valid), .irq_type(irq_type),
        .irq_num(irq_num)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) hmem[mem_addr[7:0]] <= mem_wdata;
            mem_rdata <= hmem[mem_addr[7:0]];
        end
    end

    always @(negedge clk) begin
        if (mem_req) acc_cnt = acc_cnt + 1;
        if (irq_valid) begin
            irq_cnt   = irq_cnt + 1;
            last_type = irq_type;
            last_num  = irq_num;
        end
    end

    typedef struct packed {
        logic [5:0]  cmd;
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] len;
        logic [1:0]  ityp;
        logic [11:0] inum;
        logic [8:0]  stat;
        logic        irq;
        logic [7:0]  acc;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{6'h10, 32'h0,  B,         16'd16, 2'd0, 12'd0,    9'h044, 1'b1, 8'd16}, // R4 write pattern
        '{6'h08, B,      32'h0,     16'd16, 2'd1, 12'd5,    9'h041, 1'b1, 8'd16}, // R4 read match
        '{6'h08, B+4,    32'h0,     16'd8,  2'd2, 12'd2048, 9'h042, 1'b1, 8'd8},  // R4 read mismatch
        '{6'h20, B,      B+64,      16'd16, 2'd1, 12'd32,   9'h050, 1'b1, 8'd32}, // R5 copy
        '{6'h08, B+64,   32'h0,     16'd16, 2'd0, 12'd0,    9'h041, 1'b1, 8'd16}, // R5 copied data
        '{6'h08, B+2,    32'h0,     16'd4,  2'd0, 12'd0,    9'h0C2, 1'b1, 8'd0},  // R6 unaligned src
        '{6'h20, B,      32'h2000,  16'd4,  2'd0, 12'd0,    9'h160, 1'b1, 8'd0},  // R6 dst outside
        '{6'h20, 32'h0,  B+1,       16'd4,  2'd0, 12'd0,    9'h1E0, 1'b1, 8'd0},  // R6 both bad
        '{6'h10, 32'h0,  B+240,     16'd32, 2'd0, 12'd0,    9'h148, 1'b1, 8'd0},  // R6 end past window
        '{6'h08, 32'h3,  32'h0,     16'd0,  2'd0, 12'd0,    9'h041, 1'b1, 8'd0},  // R7 zero read
        '{6'h20, 32'h7,  32'h5,     16'd0,  2'd1, 12'd1,    9'h050, 1'b1, 8'd0},  // R7 zero copy
        '{6'h01, 32'h0,  32'h0,     16'd16, 2'd0, 12'd0,    9'h040, 1'b1, 8'd0},  // R8 raise legacy
        '{6'h02, 32'h0,  32'h0,     16'd16, 2'd1, 12'd1,    9'h040, 1'b1, 8'd0},  // R8 MSI low edge
        '{6'h04, 32'h0,  32'h0,     16'd16, 2'd2, 12'd2048, 9'h040, 1'b1, 8'd0},  // R8 MSI-X top edge
        '{6'h02, 32'h0,  32'h0,     16'd16, 2'd1, 12'd33,   9'h000, 1'b0, 8'd0},  // R9 MSI too big
        '{6'h04, 32'h0,  32'h0,     16'd16, 2'd2, 12'd0,    9'h000, 1'b0, 8'd0},  // R9 MSI-X zero
        '{6'h01, 32'h0,  32'h0,     16'd16, 2'd0, 12'd1,    9'h000, 1'b0, 8'd0},  // R9 legacy nonzero
        '{6'h18, B,      B+128,     16'd16, 2'd1, 12'd1,    9'h041, 1'b1, 8'd16}, // R2 lowest bit wins
        '{6'h08, B+128,  32'h0,     16'd4,  2'd0, 12'd0,    9'h042, 1'b1, 8'd4}   // R2 no write done
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        #1;
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic start(input logic [5:0] c);
        @(negedge clk);
        #2;
        irq_cnt = 0; acc_cnt = 0;
        reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = {26'd0, c};
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        v = 32'hFFFF_FFFF;
        while (v != 0 && n < 1000) begin
            rd(3'd1, v);
            n++;
        end
        if (v != 0) check(req, v, 32'd0);
        @(negedge clk);
        @(negedge clk);
        #2;
    endtask

    initial begin
        #1_600_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 256; i++) hmem[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R11 reg reset", v, 32'd0);
        end
        check("R11 irq idle", {31'd0, irq_valid}, 32'd0);
        check("R11 mem idle", {31'd0, mem_req}, 32'd0);

        // R1 storage
        wr(3'd0, 32'hA5C3_0F96);
        rd(3'd0, v);
        check("R1 magic", v, 32'hA5C3_0F96);
        wr(3'd7, 32'h0001_2345);
        rd(3'd7, v);
        check("R1 count reg", v, 32'h0001_2345);

        // vector table
        for (int k = 0; k < NV; k++) begin
            wr(3'd3, VEC[k].src);
            wr(3'd4, VEC[k].dst);
            wr(3'd7, {16'd0, VEC[k].len});
            wr(3'd5, {30'd0, VEC[k].ityp});
            wr(3'd6, {20'd0, VEC[k].inum});
            start(VEC[k].cmd);
            wait_done("R10 done");
            rd(3'd2, v);
            check("R3 status", v, {23'd0, VEC[k].stat});
            check("R8 irq count", irq_cnt, {31'd0, VEC[k].irq});
            check("R6 access count", acc_cnt, {24'd0, VEC[k].acc});
            if (VEC[k].irq) begin
                check("R8 irq type", {30'd0, last_type}, {30'd0, VEC[k].ityp});
                check("R8 irq num", {20'd0, last_num}, {20'd0, VEC[k].inum});
            end
            if (k == 0) begin
                for (int j = 0; j < 16; j++) check("R4 pattern", {24'd0, hmem[j]}, j);
            end
            if (k == 3) begin
                for (int j = 0; j < 16; j++) check("R5 copy data", {24'd0, hmem[64+j]}, j);
            end
        end

        // R10 busy locking and status clear
        wr(3'd4, B);
        wr(3'd7, 32'd40);
        wr(3'd5, 32'd0);
        wr(3'd6, 32'd0);
        start(6'h10);
        rd(3'd1, v);
        check("R10 cmd while busy", v, 32'h10);
        rd(3'd2, v);
        check("R10 status cleared", v, 32'd0);
        wr(3'd0, 32'h1234_5678);
        wr(3'd1, 32'h20);
        wait_done("R10 done");
        rd(3'd2, v);
        check("R10 status after busy", v, 32'h044);
        check("R10 access count", acc_cnt, 32'd40);
        rd(3'd0, v);
        check("R10 magic kept", v, 32'hA5C3_0F96);
        check("R4 long pattern", {24'd0, hmem[39]}, 32'd39);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule